// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Bus Master

This block lets an internal requester run single or burst accesses over a 32-bit local bus that shares its wires between address and data. The requester presents a word address, a direction flag, a beat count from 1 to 4, and for writes a data word and byte-enable nibble per beat. Once the request is accepted, the block runs one address cycle, then one data cycle per beat. Each data cycle is stretched with wait states until the memory side pulls the ready input low.

In the address cycle the upper 30 bus bits carry the word address and the lower two bits carry the beat count. Read data is handed back to the requester beat by beat, together with the beat's index. Between accesses the block can give up the bus to another master (hold), or park in a halt state. While halted it keeps the bus driven with the last address or the last write data.

Top module: `mxbus_master`

## Requirements
- R1: After reset, and with no request, `ads_n` and `blast_n` are 1, `ale`, `bus_ad_oe`, `hold_ack` and `halted` are 0. A request is accepted (`req_ready`=1) only in an idle cycle with `hold_req` and `halt_req` low. The address cycle follows in the next cycle with `ads_n`=0, `ale`=1, `bus_ad_oe`=1, and `bus_ad_out[31:2]` equal to the word address.
- R2: In the address cycle `bus_ad_out[1:0]` holds the beat-count code: 2'b00 = 1 beat, 2'b01 = 2, 2'b10 = 3, 2'b11 = 4.
- R3: The address cycle lasts exactly one cycle. In every data cycle `ads_n`=1 and `ale`=0.
- R4: `blast_n` is 0 only during the final data beat, including all of its wait states. It is 1 in the cycle after that beat completes.
- R5: A data beat completes only on a rising edge where `rdy_n` is sampled 0; otherwise it repeats. During beat b, `xfer_addr` equals the start address plus b, modulo 2^30.
- R6: On a write data beat `bus_ad_oe`=1 and `bus_wr`=1. Each byte lane whose enable bit is 1 carries its data byte, and each lane whose enable bit is 0 is driven to 8'h00. Lane k is bits 8k+7:8k and its enable is bit k of that beat's nibble.
- R7: On a read data beat `bus_ad_oe`=0. In the cycle where `rdy_n` is 0, `rd_valid`=1, `rd_data` equals `bus_ad_in`, and `rd_beat` equals the beat index. `done` is 1 in the cycle that completes the final beat of any access.
- R8: Hold is entered only from idle, never in the middle of an access. While in hold, `hold_ack`=1, `bus_ad_oe`, `ale_oe` and `ctl_oe` are 0, and no request is accepted.
- R9: While halted, `halted`=1 and `bus_ad_oe`=1. `bus_ad_out[31:2]` holds the last write data word's bits 31:2 if the last access was a write, or the last address if it was a read. `bus_ad_out[1:0]` holds the last count code. The value stays constant until halt is left.
- R10: In idle, `hold_req` takes priority over `halt_req`, and both take priority over a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester has an access pending |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 30 | Word address of first beat |
| req_write | input | 1 | 1 = write, 0 = read |
| req_count | input | 3 | Number of beats, 1 to 4 |
| req_wdata | input | 128 | Write data, beat b at bits 32b+31:32b |
| req_be | input | 16 | Byte enables, beat b at bits 4b+3:4b |
| rd_valid | output | 1 | Read beat data valid |
| rd_data | output | 32 | Read beat data |
| rd_beat | output | 2 | Index of the returned read beat |
| done | output | 1 | Final beat of an access completes |
| xfer_addr | output | 30 | Word address of the current beat |
| bus_ad_out | output | 32 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| bus_ad_in | input | 32 | Multiplexed address/data in |
| bus_wr | output | 1 | Access direction on the bus, 1 = write |
| bus_be_n | output | 4 | Active-low byte enables in data cycles |
| ads_n | output | 1 | Address strobe, active low |
| ale | output | 1 | Address latch enable, active high |
| ale_oe | output | 1 | Output enable for ale |
| blast_n | output | 1 | Final-beat marker, active low |
| ctl_oe | output | 1 | Output enable for ads_n, blast_n, bus_wr, bus_be_n |
| rdy_n | input | 1 | Beat ready, active low |
| hold_req | input | 1 | Another master requests the bus |
| hold_ack | output | 1 | Bus released to another master |
| halt_req | input | 1 | Enter halt state |
| halted | output | 1 | Block is halted |

## Verification
The main transaction is swept over every beat count from 1 to 4, both directions, and three wait-state patterns. The wait patterns place zero, one or two wait states differently on each beat, which separates a beat that advances on a sampled ready from one that advances on time alone. Byte-enable nibbles change per beat and include single lanes, split lanes and full words, so a lane fill that ignores the enables or swaps lanes is caught. A burst starting at the top of the address space checks that the address wraps.

Hold is raised in the middle of a burst to show it waits for the access to end. Halt is entered after a write and after a read to tell the data-holding case from the address-holding case. All three requests are raised together to check the priority order.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;
  localparam int ADDR_W = BUS_W - 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_HOLD, ST_HALT
  } bus_state_e;

  // beat count 1..4 -> 2-bit code placed on the low address bits
  function automatic logic [1:0] count_code(input logic [2:0] n);
    logic [2:0] m;
    m = n - 3'd1;
    return m[1:0];
  endfunction
endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
#(
  parameter int MAX_BEATS = 4,
  localparam int BEAT_W = $clog2(MAX_BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BEAT_W:0]   req_count,
  input  logic              hold_req,
  input  logic              halt_req,
  input  logic              rdy_n,
  output bus_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              last_beat,
  output logic              beat_done,
  output logic              accept
);
  bus_state_e        nxt;
  logic [BEAT_W-1:0] last_q;
  logic [BEAT_W:0]   cnt_m1;

  assign cnt_m1    = req_count - 1'b1;
  assign accept    = (state == ST_IDLE) && req_valid && !hold_req && !halt_req;
  assign beat_done = (state == ST_DATA) && !rdy_n;
  assign last_beat = (beat == last_q);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (hold_req)       nxt = ST_HOLD;
        else if (halt_req)  nxt = ST_HALT;
        else if (req_valid) nxt = ST_ADDR;
      end
      ST_ADDR: nxt = ST_DATA;
      ST_DATA: if (beat_done && last_beat) nxt = ST_IDLE;
      ST_HOLD: if (!hold_req) nxt = ST_IDLE;
      ST_HALT: if (!halt_req) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      beat   <= '0;
      last_q <= '0;
    end else begin
      state <= nxt;
      if (accept) last_q <= cnt_m1[BEAT_W-1:0];
      if (state == ST_ADDR) beat <= '0;
      else if (beat_done && !last_beat) beat <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/mxbus_path.sv
module mxbus_path
  import mxbus_pkg::*;
#(
  parameter int MAX_BEATS = 4,
  localparam int BEAT_W = $clog2(MAX_BEATS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  bus_state_e                 state,
  input  logic [BEAT_W-1:0]          beat,
  input  logic                       accept,
  input  logic                       beat_done,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       req_write,
  input  logic [BEAT_W:0]            req_count,
  input  logic [MAX_BEATS*BUS_W-1:0] req_wdata,
  input  logic [MAX_BEATS*LANES-1:0] req_be,
  input  logic [BUS_W-1:0]           bus_ad_in,
  output logic [BUS_W-1:0]           bus_ad_out,
  output logic                       bus_ad_oe,
  output logic                       bus_wr,
  output logic [LANES-1:0]           bus_be_n,
  output logic [ADDR_W-1:0]          xfer_addr,
  output logic                       rd_valid,
  output logic [BUS_W-1:0]           rd_data,
  output logic [BEAT_W-1:0]          rd_beat
);
  logic [ADDR_W-1:0] base_q;
  logic              wr_q;
  logic [1:0]        code_q;
  logic [BUS_W-1:0]  wdata_q [MAX_BEATS];
  logic [LANES-1:0]  be_q    [MAX_BEATS];
  logic [ADDR_W-1:0] last_hi_q;
  logic [1:0]        last_code_q;
  logic [BUS_W-1:0]  cur_wd;
  logic [LANES-1:0]  cur_be;
  logic [BUS_W-1:0]  beat_data;

  assign cur_wd = wdata_q[beat];
  assign cur_be = be_q[beat];

  // one lane of write data per generate slice; disabled lanes are zero
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign beat_data[l*8 +: 8] = cur_be[l] ? cur_wd[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q      <= '0;
      wr_q        <= 1'b0;
      code_q      <= '0;
      last_hi_q   <= '0;
      last_code_q <= '0;
      for (int i = 0; i < MAX_BEATS; i++) begin
        wdata_q[i] <= '0;
        be_q[i]    <= '0;
      end
    end else begin
      if (accept) begin
        base_q <= req_addr;
        wr_q   <= req_write;
        code_q <= count_code(3'(req_count));
        for (int i = 0; i < MAX_BEATS; i++) begin
          wdata_q[i] <= req_wdata[i*BUS_W +: BUS_W];
          be_q[i]    <= req_be[i*LANES +: LANES];
        end
      end
      if (state == ST_ADDR) begin
        last_hi_q   <= base_q;
        last_code_q <= code_q;
      end else if (beat_done && wr_q) begin
        last_hi_q <= beat_data[BUS_W-1:2];
      end
    end
  end

  assign xfer_addr = base_q + ADDR_W'(beat);

  always_comb begin
    bus_ad_out = '0;
    bus_ad_oe  = 1'b0;
    unique case (state)
      ST_ADDR: begin
        bus_ad_out = {base_q, code_q};
        bus_ad_oe  = 1'b1;
      end
      ST_DATA: begin
        bus_ad_out = wr_q ? beat_data : '0;
        bus_ad_oe  = wr_q;
      end
      ST_HALT: begin
        bus_ad_out = {last_hi_q, last_code_q};
        bus_ad_oe  = 1'b1;
      end
      default: ;
    endcase
  end

  assign bus_wr   = ((state == ST_ADDR) || (state == ST_DATA)) && wr_q;
  assign bus_be_n = (state == ST_DATA) ? ~cur_be : '1;
  assign rd_valid = beat_done && !wr_q;
  assign rd_data  = rd_valid ? bus_ad_in : '0;
  assign rd_beat  = beat;
endmodule

// File: rtl/mxbus_master.sv
module mxbus_master
  import mxbus_pkg::*;
#(
  parameter int MAX_BEATS = 4,
  localparam int BEAT_W = $clog2(MAX_BEATS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       req_write,
  input  logic [BEAT_W:0]            req_count,
  input  logic [MAX_BEATS*BUS_W-1:0] req_wdata,
  input  logic [MAX_BEATS*LANES-1:0] req_be,
  output logic                       rd_valid,
  output logic [BUS_W-1:0]           rd_data,
  output logic [BEAT_W-1:0]          rd_beat,
  output logic                       done,
  output logic [ADDR_W-1:0]          xfer_addr,
  output logic [BUS_W-1:0]           bus_ad_out,
  output logic                       bus_ad_oe,
  input  logic [BUS_W-1:0]           bus_ad_in,
  output logic                       bus_wr,
  output logic [LANES-1:0]           bus_be_n,
  output logic                       ads_n,
  output logic                       ale,
  output logic                       ale_oe,
  output logic                       blast_n,
  output logic                       ctl_oe,
  input  logic                       rdy_n,
  input  logic                       hold_req,
  output logic                       hold_ack,
  input  logic                       halt_req,
  output logic                       halted
);
  bus_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic              last_beat;
  logic              beat_done;
  logic              accept;

  mxbus_seq #(.MAX_BEATS(MAX_BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
    .hold_req(hold_req), .halt_req(halt_req), .rdy_n(rdy_n),
    .state(state), .beat(beat), .last_beat(last_beat),
    .beat_done(beat_done), .accept(accept)
  );

  mxbus_path #(.MAX_BEATS(MAX_BEATS)) u_path (
    .clk(clk), .rst_n(rst_n), .state(state), .beat(beat), .accept(accept),
    .beat_done(beat_done), .req_addr(req_addr), .req_write(req_write),
    .req_count(req_count), .req_wdata(req_wdata), .req_be(req_be),
    .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_wr(bus_wr), .bus_be_n(bus_be_n), .xfer_addr(xfer_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_beat(rd_beat)
  );

  assign req_ready = accept;
  assign ads_n     = (state != ST_ADDR);
  assign ale       = (state == ST_ADDR);
  assign blast_n   = !((state == ST_DATA) && last_beat);
  assign ale_oe    = (state != ST_HOLD);
  assign ctl_oe    = (state != ST_HOLD);
  assign hold_ack  = (state == ST_HOLD);
  assign halted    = (state == ST_HALT);
  assign done      = beat_done && last_beat;
endmodule

// File: rtl/mxbus_checker.sv
module mxbus_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        ads_n,
  input logic        ale,
  input logic        blast_n,
  input logic        rdy_n,
  input logic        hold_ack,
  input logic        bus_ad_oe,
  input logic        ale_oe,
  input logic        ctl_oe,
  input logic        halted,
  input logic [31:0] bus_ad_out,
  input logic        rd_valid,
  input logic        bus_wr,
  input logic        done,
  input logic        beat_done
);
  p_addr_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (!ads_n && ale && bus_ad_oe));

  p_single_addr_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> (ads_n && !ale));

  p_blast_through_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!blast_n && rdy_n) |=> !blast_n);

  p_blast_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!blast_n && !rdy_n) |=> blast_n);

  p_done_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!blast_n && beat_done && !rdy_n));

  p_read_not_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!bus_wr && !bus_ad_oe));

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!bus_ad_oe && !ale_oe && !ctl_oe && !req_ready));

  p_halt_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> ($stable(bus_ad_out) && bus_ad_oe));

  p_modes_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_ack && halted));
endmodule

bind mxbus_master mxbus_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ads_n(ads_n), .ale(ale),
  .blast_n(blast_n), .rdy_n(rdy_n), .hold_ack(hold_ack), .bus_ad_oe(bus_ad_oe),
  .ale_oe(ale_oe), .ctl_oe(ctl_oe), .halted(halted), .bus_ad_out(bus_ad_out),
  .rd_valid(rd_valid), .bus_wr(bus_wr), .done(done), .beat_done(beat_done)
);

// File: tb/mxbus_master_bench.sv
`timescale 1ns/1ps
module mxbus_master_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [29:0]  req_addr = '0;
  logic         req_write = 1'b0;
  logic [2:0]   req_count = 3'd1;
  logic [127:0] req_wdata = '0;
  logic [15:0]  req_be = '0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic [1:0]   rd_beat;
  logic         done;
  logic [29:0]  xfer_addr;
  logic [31:0]  bus_ad_out;
  logic         bus_ad_oe;
  logic [31:0]  bus_ad_in = '0;
  logic         bus_wr;
  logic [3:0]   bus_be_n;
  logic         ads_n, ale, ale_oe, blast_n, ctl_oe;
  logic         rdy_n = 1'b1;
  logic         hold_req = 1'b0;
  logic         hold_ack;
  logic         halt_req = 1'b0;
  logic         halted;

  int n_tests = 0;
  int n_fail  = 0;
  logic [29:0] last_hi;
  logic [1:0]  last_code;

  always #4 clk = ~clk;

  mxbus_master u_mxbus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_count(req_count),
    .req_wdata(req_wdata), .req_be(req_be), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_beat(rd_beat), .done(done), .xfer_addr(xfer_addr),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_wr(bus_wr), .bus_be_n(bus_be_n), .ads_n(ads_n), .ale(ale),
    .ale_oe(ale_oe), .blast_n(blast_n), .ctl_oe(ctl_oe), .rdy_n(rdy_n),
    .hold_req(hold_req), .hold_ack(hold_ack), .halt_req(halt_req),
    .halted(halted)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [29:0] a);
    return {a, 2'b00} ^ 32'h5A3C_0F11;
  endfunction

  function automatic logic [31:0] wr_word(input logic [29:0] a, input int b);
    return 32'hC0DE_0000 ^ {a[27:0], 4'h0} ^ (32'h1111_1111 * b);
  endfunction

  function automatic logic [3:0] be_for(input int b, input int pat, input int n);
    return 4'(((b * 5 + pat * 3 + n) % 15) + 1);
  endfunction

  function automatic logic [31:0] keep_lanes(input logic [31:0] d, input logic [3:0] e);
    logic [31:0] r;
    r = 32'h0;
    if (e[0]) r = r | (d & 32'h0000_00FF);
    if (e[1]) r = r | (d & 32'h0000_FF00);
    if (e[2]) r = r | (d & 32'h00FF_0000);
    if (e[3]) r = r | (d & 32'hFF00_0000);
    return r;
  endfunction

  task automatic run_txn(input logic [29:0] addr, input bit wr, input int n,
                         input int pat, input bit hold_mid);
    logic [1:0] code;
    code = 2'(n - 1);
    @(negedge clk);
    req_addr  = addr;
    req_write = wr;
    req_count = 3'(n);
    for (int b = 0; b < 4; b++) begin
      req_wdata[b*32 +: 32] = wr_word(addr, b);
      req_be[b*4 +: 4]      = be_for(b, pat, n);
    end
    req_valid = 1'b1;
    #1 check("R1 accept", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R1 ads_n low in address cycle", {31'h0, ads_n}, 32'h0);
    check("R1 ale high in address cycle", {31'h0, ale}, 32'h1);
    check("R1 address word", {2'b00, bus_ad_out[31:2]}, {2'b00, addr});
    check("R2 count code", {30'h0, bus_ad_out[1:0]}, {30'h0, code});
    for (int b = 0; b < n; b++) begin
      logic [29:0] ea;
      int waits;
      ea    = addr + 30'(b);
      waits = (b + pat) % 3;
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        if (hold_mid && b == 1 && w == 0) hold_req = 1'b1;
        rdy_n = 1'b1;
        #1;
        check("R3 ads_n/ale in wait", {30'h0, ads_n, ale}, 32'h2);
        check("R4 blast_n during wait", {31'h0, blast_n}, (b == n - 1) ? 32'h0 : 32'h1);
        check("R5 no completion while not ready", {30'h0, done, rd_valid}, 32'h0);
        check("R5 beat address", {2'b00, xfer_addr}, {2'b00, ea});
        if (hold_mid) check("R8 no hold inside burst", {31'h0, hold_ack}, 32'h0);
      end
      @(negedge clk);
      if (hold_mid && b == 1) hold_req = 1'b1;
      rdy_n = 1'b0;
      bus_ad_in = mem_word(ea);
      #1;
      check("R3 ads_n/ale in data", {30'h0, ads_n, ale}, 32'h2);
      check("R4 blast_n on beat", {31'h0, blast_n}, (b == n - 1) ? 32'h0 : 32'h1);
      check("R5 beat address", {2'b00, xfer_addr}, {2'b00, ea});
      check("R7 done flag", {31'h0, done}, (b == n - 1) ? 32'h1 : 32'h0);
      if (hold_mid) check("R8 no hold inside burst", {31'h0, hold_ack}, 32'h0);
      if (wr) begin
        logic [3:0] e;
        e = be_for(b, pat, n);
        check("R6 write drive", {30'h0, bus_ad_oe, bus_wr}, 32'h3);
        check("R6 write lanes", bus_ad_out, keep_lanes(wr_word(addr, b), e));
        check("R6 byte enables", {28'h0, bus_be_n}, {28'h0, ~e});
        check("R7 no read strobe on write", {31'h0, rd_valid}, 32'h0);
        if (b == n - 1) last_hi = keep_lanes(wr_word(addr, b), e) >> 2;
      end else begin
        check("R7 read not driven", {31'h0, bus_ad_oe}, 32'h0);
        check("R7 read strobe", {31'h0, rd_valid}, 32'h1);
        check("R7 read data", rd_data, mem_word(ea));
        check("R7 read beat", {30'h0, rd_beat}, 32'(b));
        if (b == n - 1) last_hi = addr;
      end
    end
    last_code = code;
    @(negedge clk);
    rdy_n = 1'b1;
    #1;
    check("R4 blast_n released", {31'h0, blast_n}, 32'h1);
    check("R3 back to idle", {30'h0, ads_n, ale}, 32'h2);
  endtask

  task automatic do_halt(input string tag);
    @(negedge clk);
    halt_req = 1'b1;
    @(negedge clk);
    #1;
    check({"R9 halted ", tag}, {30'h0, halted, bus_ad_oe}, 32'h3);
    check({"R9 halt value ", tag}, bus_ad_out, {last_hi, last_code});
    @(negedge clk);
    #1 check({"R9 halt steady ", tag}, bus_ad_out, {last_hi, last_code});
    halt_req = 1'b0;
    @(negedge clk);
    #1 check("R9 halt left", {31'h0, halted}, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    last_hi = '0;
    last_code = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset strobes", {30'h0, ads_n, blast_n}, 32'h3);
    check("R1 reset outputs", {28'h0, ale, bus_ad_oe, hold_ack, halted}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R1 idle without request", {30'h0, ads_n, req_ready}, 32'h2);

    for (int n = 1; n <= 4; n++)
      for (int wr = 0; wr < 2; wr++)
        for (int pat = 0; pat < 3; pat++)
          run_txn(30'h0123_4560 + 30'(n * 64 + pat * 8), wr[0], n, pat, 1'b0);

    // address wrap at the top of the space
    run_txn(30'h3FFF_FFFE, 1'b0, 4, 1, 1'b0);

    // hold raised mid-burst: granted only after the access ends
    run_txn(30'h0000_0100, 1'b1, 4, 2, 1'b1);
    #1 check("R8 hold not yet in idle cycle", {31'h0, hold_ack}, 32'h0);
    req_valid = 1'b1;
    @(negedge clk);
    #1;
    check("R8 hold granted", {31'h0, hold_ack}, 32'h1);
    check("R8 outputs released", {29'h0, bus_ad_oe, ale_oe, ctl_oe}, 32'h0);
    check("R8 no accept in hold", {31'h0, req_ready}, 32'h0);
    req_valid = 1'b0;
    hold_req = 1'b0;
    @(negedge clk);
    #1 check("R8 hold left", {31'h0, hold_ack}, 32'h0);

    // halt after write, then after read
    run_txn(30'h0ABC_DE00, 1'b1, 3, 0, 1'b0);
    do_halt("after write");
    run_txn(30'h1357_9BDE, 1'b0, 2, 1, 1'b0);
    do_halt("after read");

    // priority: hold over halt over request
    @(negedge clk);
    hold_req = 1'b1;
    halt_req = 1'b1;
    req_valid = 1'b1;
    #1 check("R10 no accept with hold/halt", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    #1 check("R10 hold wins", {30'h0, hold_ack, halted}, 32'h2);
    hold_req = 1'b0;
    @(negedge clk);
    #1 check("R10 idle between", {30'h0, hold_ack, halted}, 32'h0);
    check("R10 halt beats request", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    #1 check("R10 halt next", {30'h0, halted, ads_n}, 32'h3);
    halt_req = 1'b0;
    @(negedge clk);
    #1 check("R10 request after halt", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    #1 check("R10 address cycle", {31'h0, ads_n}, 32'h0);
    @(negedge clk);
    rdy_n = 1'b0;
    @(negedge clk);
    rdy_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule